// File: doc/BRIEF.md
# Microcontroller Internal Data Memory Unit

This block is the on-chip data store of a small 8-bit microcontroller core. It holds a 256-byte RAM and resolves four kinds of access against it: direct byte, indirect byte, working-register (bank relative) and single-bit. The core's status word is kept inside the block, so the two bank-select bits can steer working-register accesses without a round trip to another unit. Accesses that land in the special-register space leave the block on a plain read/write port. A peripheral responder on that port returns read data one cycle after it sees a read strobe.

A request is offered with a kind, an 8-bit address, write data and a write flag. It is taken on a clock edge where `req_ready` is high. `done` pulses when the request completes, and `rdata` is valid in that same cycle. Byte and working-register requests complete in the cycle after acceptance. A bit write is carried out as a read of the whole byte followed by a write-back of the merged byte, so it completes one cycle later.

Top module: `dmem_unit`

## Requirements
- R1: After reset `done`, `sfr_rd` and `sfr_wr` are low, `req_ready` is high and `status_word` is 00H.
- R2: A direct request (`req_kind`=0) to an address in 00H–7FH reads or writes that RAM byte. `done` pulses in the cycle after acceptance, and read data is on `rdata` in that cycle.
- R3: An indirect request (`req_kind`=1) reaches the RAM byte at the full 8-bit address, including the upper half 80H–FFH.
- R4: A direct request to 80H–FFH goes only to the special-register port and never touches RAM. A read returns the port's data, which the responder supplies one cycle after `sfr_rd`.
- R5: A working-register request (`req_kind`=2) with register number n = `req_addr[2:0]` uses RAM byte {status bit 4, status bit 3, n}.
- R6: The status word lives at special-register address D0H. Direct and bit writes there update the local `status_word` and are also sent out on the port. Reads of D0H return the local copy. New bank bits apply to the next request.
- R7: A bit request (`req_kind`=3) with address 00H–7FH targets RAM byte 20H + addr[6:3], bit addr[2:0]. A bit read returns that bit in `rdata[0]` and zeros in the other bits. A bit write uses only `req_wdata[0]`.
- R8: A bit address in 80H–FFH targets special register (addr & F8H), bit addr[2:0]. A bit write there issues exactly one port read and then one port write of the merged byte. The port is never read and written in the same cycle.
- R9: A bit write leaves all other bits of the byte unchanged. `done` is low and `req_ready` is low in the cycle after acceptance, and `done` pulses one cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_kind | input | 2 | 0 direct, 1 indirect, 2 working register, 3 bit |
| req_addr | input | 8 | Byte, register or bit address |
| req_wdata | input | 8 | Write data (bit 0 for bit writes) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ready | output | 1 | Block idle, request may be taken |
| done | output | 1 | Request completed this cycle |
| rdata | output | 8 | Read result, valid while done is high |
| status_word | output | 8 | Local status word |
| sfr_addr | output | 8 | Special-register port address |
| sfr_rd | output | 1 | Special-register read strobe |
| sfr_wr | output | 1 | Special-register write strobe |
| sfr_wdata | output | 8 | Special-register write data |
| sfr_rdata | input | 8 | Special-register read data, one cycle after sfr_rd |

## Verification
The hardest case to reach is a working-register access that depends on bank bits set by an earlier bit write to the status word. That write sends a read-modify-write through the local status copy while also forwarding to the port. The stimulus first sets the bank bits with a byte write, then flips one bank bit with a bit write at D4H. It then writes and reads a working register and checks, through an indirect read, that the data landed in the bank-3 byte. In the same run the bench counts port strobes during a special-register bit write, to confirm that exactly one read is followed by one write.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  localparam int ADDR_W = 8;
  localparam int BIT_IDX_W = 3;

  typedef enum logic [1:0] {
    AK_DIRECT   = 2'd0,
    AK_INDIRECT = 2'd1,
    AK_BANKREG  = 2'd2,
    AK_BIT      = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic                 to_sfr;
    logic                 to_status;
    logic [ADDR_W-1:0]    byte_addr;
    logic [BIT_IDX_W-1:0] bit_sel;
  } tgt_t;
endpackage

// File: rtl/dmem_decode.sv
module dmem_decode
  import dmem_pkg::*;
#(
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'hD0,
  parameter logic [ADDR_W-1:0] BITRAM_BASE = 8'h20
) (
  input  acc_kind_e         kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        bank_sel,
  output tgt_t              tgt
);
  always_comb begin
    tgt = '0;
    tgt.bit_sel = addr[BIT_IDX_W-1:0];
    case (kind)
      AK_DIRECT: begin
        tgt.to_sfr    = addr[ADDR_W-1];
        tgt.byte_addr = addr;
      end
      AK_INDIRECT: tgt.byte_addr = addr;
      AK_BANKREG:  tgt.byte_addr = {{(ADDR_W-5){1'b0}}, bank_sel, addr[2:0]};
      default: begin
        if (addr[ADDR_W-1]) begin
          tgt.to_sfr    = 1'b1;
          tgt.byte_addr = {addr[ADDR_W-1:BIT_IDX_W], {BIT_IDX_W{1'b0}}};
        end else begin
          tgt.byte_addr = BITRAM_BASE
                        + {{(BIT_IDX_W+1){1'b0}}, addr[ADDR_W-2:BIT_IDX_W]};
        end
      end
    endcase
    tgt.to_status = tgt.to_sfr && (tgt.byte_addr == STATUS_ADDR);
  end
endmodule

// File: rtl/dmem_ram.sv
module dmem_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      q <= mem[addr];
    end
  end
endmodule

// File: rtl/dmem_bitop.sv
module dmem_bitop #(
  parameter int DW = 8,
  parameter int IW = 3
) (
  input  logic [DW-1:0] byte_in,
  input  logic [IW-1:0] bit_sel,
  input  logic          bit_val,
  output logic          bit_out,
  output logic [DW-1:0] byte_out
);
  always_comb begin
    bit_out           = byte_in[bit_sel];
    byte_out          = byte_in;
    byte_out[bit_sel] = bit_val;
  end
endmodule

// File: rtl/dmem_unit.sv
module dmem_unit
  import dmem_pkg::*;
#(
  parameter int                DATA_W      = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'hD0,
  parameter logic [ADDR_W-1:0] BITRAM_BASE = 8'h20,
  parameter int                BANK_LSB    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_write,
  output logic              req_ready,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] status_word,
  output logic [ADDR_W-1:0] sfr_addr,
  output logic              sfr_rd,
  output logic              sfr_wr,
  output logic [DATA_W-1:0] sfr_wdata,
  input  logic [DATA_W-1:0] sfr_rdata
);
  typedef enum logic {ST_IDLE, ST_MERGE} st_e;

  st_e               st;
  acc_kind_e         kind_in;
  tgt_t              dec, l_tgt;
  logic              accept, is_bit_in, l_bit, l_val;
  logic [DATA_W-1:0] status_q, ram_q, src_byte, merged;
  logic              bit_out, ram_en, ram_we;
  logic [ADDR_W-1:0] ram_addr;
  logic [DATA_W-1:0] ram_wdata;

  assign kind_in   = acc_kind_e'(req_kind);
  assign is_bit_in = (kind_in == AK_BIT);
  assign accept    = req_valid && (st == ST_IDLE);
  assign req_ready = (st == ST_IDLE);
  assign status_word = status_q;

  dmem_decode #(.STATUS_ADDR(STATUS_ADDR), .BITRAM_BASE(BITRAM_BASE)) dec_i (
    .kind(kind_in), .addr(req_addr),
    .bank_sel(status_q[BANK_LSB+1:BANK_LSB]), .tgt(dec)
  );

  // RAM port: request address when idle, latched target during write-back
  always_comb begin
    if (st == ST_MERGE) begin
      ram_en    = 1'b1;
      ram_we    = !l_tgt.to_sfr;
      ram_addr  = l_tgt.byte_addr;
      ram_wdata = merged;
    end else begin
      ram_en    = accept;
      ram_we    = accept && req_write && !is_bit_in && !dec.to_sfr;
      ram_addr  = dec.byte_addr;
      ram_wdata = req_wdata;
    end
  end

  dmem_ram #(.AW(ADDR_W), .DW(DATA_W)) ram_i (
    .clk(clk), .en(ram_en), .we(ram_we), .addr(ram_addr),
    .wdata(ram_wdata), .q(ram_q)
  );

  assign src_byte = l_tgt.to_status ? status_q
                  : l_tgt.to_sfr    ? sfr_rdata : ram_q;

  dmem_bitop #(.DW(DATA_W), .IW(BIT_IDX_W)) bitop_i (
    .byte_in(src_byte), .bit_sel(l_tgt.bit_sel), .bit_val(l_val),
    .bit_out(bit_out), .byte_out(merged)
  );

  assign rdata = l_bit ? {{(DATA_W-1){1'b0}}, bit_out} : src_byte;

  // Special-register port
  always_comb begin
    if (st == ST_MERGE) begin
      sfr_rd    = 1'b0;
      sfr_wr    = l_tgt.to_sfr;
      sfr_addr  = l_tgt.byte_addr;
      sfr_wdata = merged;
    end else begin
      sfr_rd    = accept && dec.to_sfr && (!req_write || is_bit_in);
      sfr_wr    = accept && dec.to_sfr && req_write && !is_bit_in;
      sfr_addr  = dec.byte_addr;
      sfr_wdata = req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      done     <= 1'b0;
      status_q <= '0;
      l_tgt    <= '0;
      l_bit    <= 1'b0;
      l_val    <= 1'b0;
    end else begin
      done <= (accept && !(is_bit_in && req_write)) || (st == ST_MERGE);
      if (st == ST_MERGE) begin
        st <= ST_IDLE;
        if (l_tgt.to_status) status_q <= merged;
      end else if (accept) begin
        l_tgt <= dec;
        l_bit <= is_bit_in;
        l_val <= req_wdata[0];
        if (is_bit_in && req_write) st <= ST_MERGE;
        if (dec.to_status && req_write && !is_bit_in) status_q <= req_wdata;
      end
    end
  end

  a_r4_direct_high_no_ram: assert property (@(posedge clk) disable iff (rst)
    (accept && kind_in == AK_DIRECT && req_addr[ADDR_W-1]) |-> !ram_we);
  a_r5_bank_map: assert property (@(posedge clk) disable iff (rst)
    (accept && kind_in == AK_BANKREG)
      |-> (ram_addr[4:3] == status_q[BANK_LSB+1:BANK_LSB]));
  a_r8_port_excl: assert property (@(posedge clk) disable iff (rst)
    !(sfr_rd && sfr_wr));
  a_r8_merge_sfr_write: assert property (@(posedge clk) disable iff (rst)
    (st == ST_MERGE && l_tgt.to_sfr) |-> (sfr_wr && !ram_we));
  a_r9_merge_gap: assert property (@(posedge clk) disable iff (rst)
    (accept && is_bit_in && req_write) |=> (!done && !req_ready));
  a_r9_merge_done: assert property (@(posedge clk) disable iff (rst)
    (st == ST_MERGE) |=> done);
endmodule

// File: tb/dmem_unit_tb_top.sv
module dmem_unit_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = '0;
  logic [7:0] req_addr = '0, req_wdata = '0;
  logic req_write = 1'b0;
  logic req_ready, done, sfr_rd, sfr_wr;
  logic [7:0] rdata, status_word, sfr_addr, sfr_wdata;
  logic [7:0] sfr_rdata = '0;
  logic [7:0] sfr_regs [256];
  int n_rd = 0, n_wr = 0;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  dmem_unit dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
    .req_ready(req_ready), .done(done), .rdata(rdata),
    .status_word(status_word), .sfr_addr(sfr_addr), .sfr_rd(sfr_rd),
    .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
  );

  // Special-register responder: one-cycle read latency
  initial for (int i = 0; i < 256; i++) sfr_regs[i] = 8'h00;
  always @(posedge clk) begin
    if (sfr_wr) begin sfr_regs[sfr_addr] <= sfr_wdata; n_wr <= n_wr + 1; end
    if (sfr_rd) begin sfr_rdata <= sfr_regs[sfr_addr]; n_rd <= n_rd + 1; end
  end

  typedef struct packed {
    logic [1:0] k; logic [7:0] a; logic [7:0] d; logic w; logic [7:0] e; logic [3:0] rq;
  } vec_t;
  localparam int NV = 38;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 8'h05, 8'hA5, 1'b1, 8'h00, 4'd2},  // R2
    '{2'd0, 8'h05, 8'h00, 1'b0, 8'hA5, 4'd2},  // R2
    '{2'd1, 8'h90, 8'h3C, 1'b1, 8'h00, 4'd3},  // R3
    '{2'd1, 8'h90, 8'h00, 1'b0, 8'h3C, 4'd3},  // R3
    '{2'd0, 8'h90, 8'h77, 1'b1, 8'h00, 4'd4},  // R4
    '{2'd1, 8'h90, 8'h00, 1'b0, 8'h3C, 4'd4},  // R4 upper RAM untouched
    '{2'd0, 8'h90, 8'h00, 1'b0, 8'h77, 4'd4},  // R4 from port
    '{2'd2, 8'h02, 8'h11, 1'b1, 8'h00, 4'd5},  // R5 bank 0
    '{2'd1, 8'h02, 8'h00, 1'b0, 8'h11, 4'd5},  // R5
    '{2'd0, 8'hD0, 8'h18, 1'b1, 8'h00, 4'd6},  // R6 bank 3
    '{2'd2, 8'h02, 8'h22, 1'b1, 8'h00, 4'd5},  // R5 -> 1AH
    '{2'd0, 8'h1A, 8'h00, 1'b0, 8'h22, 4'd5},  // R5
    '{2'd0, 8'hD0, 8'h00, 1'b0, 8'h18, 4'd6},  // R6
    '{2'd0, 8'hD0, 8'h08, 1'b1, 8'h00, 4'd6},  // R6 bank 1
    '{2'd2, 8'h07, 8'h5E, 1'b1, 8'h00, 4'd5},  // R5 -> 0FH
    '{2'd1, 8'h0F, 8'h00, 1'b0, 8'h5E, 4'd5},  // R5
    '{2'd0, 8'h20, 8'h00, 1'b1, 8'h00, 4'd7},  // R7
    '{2'd0, 8'h2F, 8'h00, 1'b1, 8'h00, 4'd7},  // R7
    '{2'd3, 8'h00, 8'h01, 1'b1, 8'h00, 4'd7},  // R7 LSB of 20H
    '{2'd3, 8'h7F, 8'hFF, 1'b1, 8'h00, 4'd7},  // R7 MSB of 2FH
    '{2'd0, 8'h20, 8'h00, 1'b0, 8'h01, 4'd7},  // R7
    '{2'd0, 8'h2F, 8'h00, 1'b0, 8'h80, 4'd7},  // R7
    '{2'd3, 8'h7F, 8'h00, 1'b0, 8'h01, 4'd7},  // R7
    '{2'd3, 8'h7E, 8'h00, 1'b0, 8'h00, 4'd7},  // R7
    '{2'd0, 8'h25, 8'hF0, 1'b1, 8'h00, 4'd9},  // R9
    '{2'd3, 8'h2C, 8'hFE, 1'b1, 8'h00, 4'd9},  // R9 clear bit 4 of 25H
    '{2'd0, 8'h25, 8'h00, 1'b0, 8'hE0, 4'd9},  // R9 others kept
    '{2'd0, 8'h88, 8'h00, 1'b1, 8'h00, 4'd8},  // R8
    '{2'd3, 8'h8B, 8'h01, 1'b1, 8'h00, 4'd8},  // R8 set bit 3 of 88H
    '{2'd0, 8'h88, 8'h00, 1'b0, 8'h08, 4'd8},  // R8
    '{2'd3, 8'h8B, 8'h00, 1'b0, 8'h01, 4'd8},  // R8
    '{2'd3, 8'h8A, 8'h00, 1'b0, 8'h00, 4'd8},  // R8
    '{2'd3, 8'hD4, 8'h01, 1'b1, 8'h00, 4'd6},  // R6 bit 4 of status
    '{2'd0, 8'hD0, 8'h00, 1'b0, 8'h18, 4'd6},  // R6
    '{2'd3, 8'hD3, 8'h00, 1'b0, 8'h01, 4'd6},  // R6 bit 3 of status
    '{2'd2, 8'h07, 8'h99, 1'b1, 8'h00, 4'd5},  // R5 bank 3 -> 1FH
    '{2'd1, 8'h1F, 8'h00, 1'b0, 8'h99, 4'd5},  // R5
    '{2'd1, 8'h0F, 8'h00, 1'b0, 8'h5E, 4'd5}   // R5 bank 1 byte kept
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic [1:0] k, input logic [7:0] a, input logic [7:0] d,
                        input logic w, input string tag, output logic [7:0] r);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = d; req_write = w;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (w && k == 2'd3) begin
      chk({tag, " R9 gap done/ready"}, {6'd0, done, req_ready}, 8'h00);
      @(negedge clk);
    end
    chk({tag, " done"}, {7'd0, done}, 8'h01);
    r = rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int rd0, wr0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 done", {7'd0, done}, 8'h00);
    chk("R1 ready", {7'd0, req_ready}, 8'h01);
    chk("R1 status", status_word, 8'h00);
    chk("R1 port strobes", {6'd0, sfr_rd, sfr_wr}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      string tg;
      tg = $sformatf("R%0d row%0d", TBL[i].rq, i);
      do_req(TBL[i].k, TBL[i].a, TBL[i].d, TBL[i].w, tg, r);
      if (!TBL[i].w) chk(tg, r, TBL[i].e);
    end

    // R6: status writes were forwarded on the port; local copy matches
    chk("R6 forwarded status", sfr_regs[8'hD0], 8'h18);
    chk("R6 status_word", status_word, 8'h18);

    // R8: one port read then one port write for a bit write
    rd0 = n_rd; wr0 = n_wr;
    do_req(2'd3, 8'h89, 8'h01, 1'b1, "R8", r);
    chk("R8 port reads", 8'(n_rd - rd0), 8'h01);
    chk("R8 port writes", 8'(n_wr - wr0), 8'h01);
    do_req(2'd0, 8'h88, 8'h00, 1'b0, "R8", r);
    chk("R8 merged byte", r, 8'h0A);

    // R1: reset again clears the status word
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 status after reset", status_word, 8'h00);
    chk("R1 ready after reset", {7'd0, req_ready}, 8'h01);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule